// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Port

This block models the device side of a converter's 32-bit serial readout port as synchronous logic. The converter core is outside the block. It delivers a finished result on a parallel port: a 28-bit code made of 24 result bits and 4 sub-LSBs, plus a sign flag, an extended-range flag and a clip flag, all qualified by a one-cycle done strobe. A host reads the word over an active-low select, a serial clock and a serial data line. The data line is modelled as a data bit with a separate output enable.

The first bit a host sees after selecting the device is a live end-of-conversion flag. It reads high while a conversion runs and drops low as soon as the result is ready, with no serial clock needed. The host can therefore poll it. Once the result is ready, each falling serial clock edge advances the word by one bit, most significant bit first. The 32nd falling edge ends the word and starts the next conversion. The line then reads high again, which is the end-of-conversion flag of the next word. If the host deselects early, the readout is abandoned and the same word is offered again from its first bit at the next selection.

Select and serial clock are asynchronous to the system clock. Each passes through a two-flop synchronizer before edge detection.

Top module: `sdadc_readout_port`

## Requirements
- R1: While select is high (deselected), `sdo_oe` is low and `sdo` is 0. Serial clock edges received while deselected do not move the readout position, so the next selection starts at bit 31.
- R2: While selected at the first bit, `sdo` shows the end-of-conversion flag. It is 1 while a conversion runs and falls to 0 within three system clocks of `conv_done`, without any serial clock edge.
- R3: The word is sent most significant bit first, with one bit advanced per falling serial clock edge. Bit 31 is the end-of-conversion flag, bit 30 is always 0, bit 29 is the sign (1 for a positive input), bit 28 is the extended-range flag, and bits 27..0 are the code (bits 27..4 result, bits 3..0 sub-LSBs).
- R4: On the 32nd falling edge the block pulses `conv_start` for exactly one system clock, and a new conversion begins. `sdo` then reads 1.
- R5: If the clip and sign inputs are both 1 at `conv_done`, the block sends bit 28 = 1 and code 28'h3FFFFFF, whatever code was supplied.
- R6: If clip is 1 and sign is 0 at `conv_done`, the block sends bit 28 = 1 and code 28'hC000000, whatever code was supplied.
- R7: The result is captured only by a `conv_done` that arrives while a conversion runs. A `conv_done` that arrives once the result is ready does not change the word that is sent.
- R8: If the host deselects before the 32nd falling edge, `sdo_oe` goes low and `conv_start` does not pulse. The next selection shows end-of-conversion 0 at bit 31 and resends the whole captured word.
- R9: While a conversion runs, serial clock edges do not advance the readout. After `conv_done`, a full read starts at bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; a conversion starts running |
| cs_n | input | 1 | Active-low select from the host (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| conv_done | input | 1 | One-cycle strobe: conversion result is valid |
| res_code | input | 28 | Result code: 24 result bits and 4 sub-LSBs |
| res_sign | input | 1 | Sign of the input, 1 for positive |
| res_exr | input | 1 | Input is outside the normal range |
| res_clip | input | 1 | Input is beyond the clamp limits; code is replaced |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable for the serial data line |
| conv_start | output | 1 | One-cycle pulse that starts the next conversion |

## Verification
The hardest situations to reach from the ports are an abandoned readout part way through the word, and a stray done strobe that arrives after the result was captured. Both need a precise ordering of select, serial clock and strobe across the synchronizer delay. The bench shifts a chosen number of bits, deselects, and then confirms that a fresh selection resends the full word without a conversion start. It also injects a second done strobe carrying a different code between capture and readout, and checks that the original code is what comes out. The format is then swept over every combination of sign, range and clip with several arithmetic codes.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

    localparam int DEF_CODE_W = 28;
    localparam int HDR_W      = 4;

    typedef enum logic {
        PH_READY   = 1'b0,
        PH_CONVERT = 1'b1
    } phase_e;

    typedef struct packed {
        logic sign;
        logic exr;
    } status_t;

    // Header order: end-of-conversion, fixed zero, sign, extended range
    function automatic logic [HDR_W-1:0] make_header(phase_e ph, status_t st);
        return {ph == PH_CONVERT, 1'b0, st.sign, st.exr};
    endfunction

endpackage

// File: rtl/sdadc_edge_sync.sv
module sdadc_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0,
    parameter bit   FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic pulse
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {(STAGES+1){RST_VAL}};
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign level = chain[STAGES-1];

    generate
        if (FALLING) begin : g_fall
            assign pulse = chain[STAGES] & ~chain[STAGES-1];
        end else begin : g_rise
            assign pulse = ~chain[STAGES] & chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sdadc_frame_builder.sv
module sdadc_frame_builder
    import sdadc_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic              sign_in,
    input  logic              exr_in,
    input  logic              clip_in,
    output status_t           st_q,
    output logic [CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] CLAMP_HI = {4'b0011, {(CODE_W-4){1'b1}}};
    localparam logic [CODE_W-1:0] CLAMP_LO = {4'b1100, {(CODE_W-4){1'b0}}};

    status_t           st_d;
    logic [CODE_W-1:0] code_d;

    always_comb begin
        st_d.sign = sign_in;
        st_d.exr  = exr_in | clip_in;
        if (!clip_in)     code_d = code_in;
        else if (sign_in) code_d = CLAMP_HI;
        else              code_d = CLAMP_LO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            code_q <= '0;
        end else if (load) begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    // R7: captured word only changes on a qualified load
    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(code_q) && $stable(st_q)));
endmodule

// File: rtl/sdadc_readout_port.sv
module sdadc_readout_port
    import sdadc_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] res_code,
    input  logic              res_sign,
    input  logic              res_exr,
    input  logic              res_clip,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              conv_start
);
    localparam int WORD_W = CODE_W + HDR_W;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);

    logic              cs_lvl, cs_release, sck_lvl, sck_fall, cs_sel;
    logic              load;
    phase_e            phase;
    logic [IDX_W-1:0]  idx;
    status_t           st_q;
    logic [CODE_W-1:0] code_q;
    logic [WORD_W-1:0] word;

    sdadc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALLING(1'b0)) u_cs_sync (
        .clk(clk), .rst(rst), .din(cs_n), .level(cs_lvl), .pulse(cs_release));

    sdadc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALLING(1'b1)) u_sck_sync (
        .clk(clk), .rst(rst), .din(sclk), .level(sck_lvl), .pulse(sck_fall));

    assign cs_sel = ~cs_lvl;
    assign load   = conv_done && (phase == PH_CONVERT);

    sdadc_frame_builder #(.CODE_W(CODE_W)) u_frame (
        .clk(clk), .rst(rst), .load(load),
        .code_in(res_code), .sign_in(res_sign), .exr_in(res_exr), .clip_in(res_clip),
        .st_q(st_q), .code_q(code_q));

    assign word   = {make_header(phase, st_q), code_q};
    assign sdo    = cs_sel ? word[idx] : 1'b0;
    assign sdo_oe = cs_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_CONVERT;
            idx        <= TOP_IDX;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            if (load) phase <= PH_READY;
            if (cs_release) begin
                idx <= TOP_IDX;
            end else if (cs_sel && sck_fall && phase == PH_READY) begin
                if (idx == '0) begin
                    idx        <= TOP_IDX;
                    phase      <= PH_CONVERT;
                    conv_start <= 1'b1;
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    // R1 / R8: after deselection the position is back at the first bit
    assert_deselect_rewinds_R1: assert property (@(posedge clk) disable iff (rst)
        !cs_sel |=> idx == TOP_IDX);

    // R2: the end-of-conversion flag only drops in answer to a done strobe
    assert_eoc_needs_done_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READY && $past(phase == PH_CONVERT)) |-> $past(conv_done));

    // R3: one step per qualified falling edge
    assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
        (cs_sel && sck_fall && phase == PH_READY && idx != '0) |=> idx == $past(idx) - 1'b1);

    // R3: a detected falling edge leaves the synchronized clock low
    assert_sync_edge_R3: assert property (@(posedge clk) disable iff (rst)
        sck_fall |-> !sck_lvl);

    // R4: restart pulse is single and coincides with a fresh conversion
    assert_restart_state_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (phase == PH_CONVERT && idx == TOP_IDX));
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R9: no progress through the word while converting
    assert_idle_converting_R9: assert property (@(posedge clk) disable iff (rst)
        phase == PH_CONVERT |-> idx == TOP_IDX);
endmodule

// File: tb/sdadc_readout_port_test.sv
module sdadc_readout_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        conv_done = 1'b0;
    logic [27:0] res_code = '0;
    logic        res_sign = 1'b0;
    logic        res_exr = 1'b0;
    logic        res_clip = 1'b0;
    logic        sdo, sdo_oe, conv_start;

    int total = 0;
    int fails = 0;
    int starts = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sdadc_readout_port uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .conv_done(conv_done),
        .res_code(res_code), .res_sign(res_sign), .res_exr(res_exr), .res_clip(res_clip),
        .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start));

    always @(posedge clk) if (!rst && conv_start) starts++;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(bit s, bit e, bit c, logic [27:0] code);
        if (c) return {2'b00, s, 1'b1, (s ? 28'h3FFFFFF : 28'hC000000)};
        return {2'b00, s, e, code};
    endfunction

    task automatic finish_conv(logic [27:0] code, bit s, bit e, bit c);
        res_code = code; res_sign = s; res_exr = e; res_clip = c;
        conv_done = 1'b1; tick(1); conv_done = 1'b0; tick(3);
    endtask

    task automatic pulse_sclk(int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; tick(5); sclk = 1'b0; tick(5);
        end
    endtask

    task automatic read_word(output logic [31:0] w);
        for (int i = 0; i < 32; i++) begin
            w[31-i] = sdo;
            sclk = 1'b1; tick(5); sclk = 1'b0; tick(5);
        end
    endtask

    initial begin
        logic [31:0] got, exp;
        int s0;
        tick(4); rst = 1'b0; tick(4);

        chk(sdo_oe == 1'b0, "R1 reset oe", 32'(sdo_oe), 32'h0);
        cs_n = 1'b0; tick(4);
        chk(sdo_oe == 1'b1, "R1 select oe", 32'(sdo_oe), 32'h1);
        chk(sdo == 1'b1, "R2 eoc high converting", 32'(sdo), 32'h1);
        pulse_sclk(3);
        chk(sdo == 1'b1, "R9 clocks ignored converting", 32'(sdo), 32'h1);
        finish_conv(28'h1234567, 1'b1, 1'b0, 1'b0);
        chk(sdo == 1'b0, "R2 eoc live drop", 32'(sdo), 32'h0);
        read_word(got);
        exp = expect_word(1'b1, 1'b0, 1'b0, 28'h1234567);
        chk(got == exp, "R9 R3 first word", got, exp);
        chk(sdo == 1'b1, "R4 line high after 32nd", 32'(sdo), 32'h1);
        chk(starts == 1, "R4 conv_start count", 32'(starts), 32'h1);
        cs_n = 1'b1; tick(4);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1 deselect oe", {30'b0, sdo_oe, sdo}, 32'h0);

        // R7: a second strobe after capture is ignored; R1: clocks while deselected ignored
        finish_conv(28'hABCDEF1, 1'b0, 1'b1, 1'b0);
        finish_conv(28'h5555555, 1'b1, 1'b0, 1'b1);
        pulse_sclk(5);
        chk(sdo_oe == 1'b0, "R1 oe low while clocking", 32'(sdo_oe), 32'h0);
        cs_n = 1'b0; tick(4);
        read_word(got);
        exp = expect_word(1'b0, 1'b1, 1'b0, 28'hABCDEF1);
        chk(got == exp, "R7 R1 word kept", got, exp);
        cs_n = 1'b1; tick(4);

        // R8: abort part way
        finish_conv(28'h0F0F0F0, 1'b1, 1'b1, 1'b0);
        s0 = starts;
        cs_n = 1'b0; tick(4);
        pulse_sclk(10);
        cs_n = 1'b1; tick(4);
        chk(sdo_oe == 1'b0, "R8 abort oe", 32'(sdo_oe), 32'h0);
        chk(starts == s0, "R8 no start on abort", 32'(starts), 32'(s0));
        cs_n = 1'b0; tick(4);
        chk(sdo == 1'b0, "R8 restart at eoc", 32'(sdo), 32'h0);
        read_word(got);
        exp = expect_word(1'b1, 1'b1, 1'b0, 28'h0F0F0F0);
        chk(got == exp, "R8 full word after abort", got, exp);
        chk(starts == s0 + 1, "R4 start after full read", 32'(starts), 32'(s0 + 1));
        cs_n = 1'b1; tick(4);

        // Sweep of format: R3, R5 (clip positive), R6 (clip negative)
        for (int k = 0; k < 24; k++) begin
            bit s, e, c;
            logic [27:0] code;
            s = k[0]; e = k[1]; c = k[2];
            code = 28'((k + 1) * 32'h09E3779B) ^ 28'(k << 20);
            finish_conv(code, s, e, c);
            cs_n = 1'b0; tick(4);
            read_word(got);
            exp = expect_word(s, e, c, code);
            if (c && s)      chk(got == exp, "R5 clamp high", got, exp);
            else if (c)      chk(got == exp, "R6 clamp low", got, exp);
            else             chk(got == exp, "R3 sweep word", got, exp);
            chk(sdo == 1'b1, "R4 eoc of next word", 32'(sdo), 32'h1);
            cs_n = 1'b1; tick(4);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  %0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule